// File: doc/BRIEF.md
# Serial Converter Frame Reader

This block is the host end of a three-wire link to a 12-bit successive-approximation converter that has its own conversion clock. A one-cycle start request opens a frame. The block lowers chip-select, waits out a setup interval, and then toggles the serial clock 16 times. The clock idles low, and the incoming data bit is captured at the moment the clock falls. After the 16th falling edge the block keeps chip-select low for a conversion-hold interval, so the converter can finish converting the sample it has just taken. It then raises chip-select and holds it high for a minimum recovery time before it accepts another request.

Of the 16 captured bits, the first 12 (most significant first) are the result. The last four are dropped. The result is presented with a one-cycle valid strobe and held until the next frame completes. Every interval is a parameter counted in system-clock cycles: the half period of the serial clock, the setup time, the conversion hold and the recovery gap. This lets one design meet the converter's limits at any system clock rate.

Control is one state machine. Its states are IDLE, SETUP, SCLK_HI, SCLK_LO, CONVERT and GAP. The transitions are as follows. IDLE goes to SETUP on start. SETUP goes to SCLK_HI when the setup count expires. SCLK_HI goes to SCLK_LO when the half period expires, and at that point a bit is captured. After the 16th bit, SCLK_HI goes to CONVERT instead. SCLK_LO returns to SCLK_HI when the half period expires. CONVERT goes to GAP when the hold count expires, and at that point the result is published. GAP returns to IDLE when the recovery count expires.

Top module: `adc_frame_reader`

## Requirements
- R1: After reset, chip-select is high, the serial clock is low, busy and result_valid are low, and result is zero.
- R2: The serial clock is low whenever chip-select is high.
- R3: Each frame has exactly 16 serial-clock pulses. Each high phase and each low phase between pulses lasts HALF_DIV system cycles.
- R4: Data is sampled when the serial clock falls. The first sampled bit is bit 15. result[11:0] equals received bits 15..4, and bits 3..0 have no effect on result.
- R5: The first serial-clock rise comes exactly SETUP_CYC cycles after chip-select falls, so the first falling edge comes SETUP_CYC+HALF_DIV cycles after it.
- R6: Chip-select stays low for exactly CONV_CYC cycles after the 16th falling edge. The whole low time is SETUP_CYC + 31*HALF_DIV + CONV_CYC cycles.
- R7: Between frames, chip-select stays high for at least GAP_CYC cycles, including when start is held high continuously.
- R8: result_valid is a single-cycle pulse. It is asserted in the first cycle in which chip-select is high again after a frame.
- R9: busy is high from the cycle after an accepted start until the recovery gap ends. A start that arrives while busy is high begins no frame.
- R10: result changes only in a cycle in which result_valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Frame request, accepted only while idle |
| adc_miso | input | 1 | Serial data from the converter |
| adc_cs_n | output | 1 | Chip-select to the converter, active low |
| adc_sclk | output | 1 | Serial clock to the converter |
| busy | output | 1 | High while a frame or its recovery gap is in progress |
| result_valid | output | 1 | One-cycle strobe when a new result is available |
| result | output | 12 | Most recent conversion result |

## Verification
The bench watches the link pins cycle by cycle and measures four intervals: the setup from chip-select fall to the first clock rise, each clock phase, the hold from the last falling edge to chip-select rise, and the recovery gap during back-to-back frames. A design that cut any of these short would corrupt the converter's next sample, and a miscounted bit counter would show up as 15 or 17 pulses. The data patterns place distinct values in the kept field and in the four discarded bits, so a capture on the wrong clock edge, an off-by-one alignment, or keeping the wrong nibble changes the result. Start requests issued in the middle of a frame must not add a chip-select fall. The result must hold through idle stretches, so a design that republished it or re-armed early would be caught.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_SCLK_HI,
        ST_SCLK_LO,
        ST_CONVERT,
        ST_GAP
    } rd_state_t;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/adc_rd_timer.sv
module adc_rd_timer #(
    parameter int unsigned TW = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          done
);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/adc_rd_shifter.sv
module adc_rd_shifter #(
    parameter int unsigned FRAME_BITS = 16,
    parameter int unsigned KEEP_BITS  = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clear,
    input  logic                 shift_en,
    input  logic                 din,
    output logic [KEEP_BITS-1:0] kept
);

    logic [FRAME_BITS-1:0] sr_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            sr_q <= '0;
        end else if (shift_en) begin
            sr_q <= {sr_q[FRAME_BITS-2:0], din};
        end
    end

    // Earliest received bits sit at the top; the trailing bits are dropped.
    assign kept = sr_q[FRAME_BITS-1 -: KEEP_BITS];

endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader #(
    parameter int unsigned FRAME_BITS = 16,
    parameter int unsigned KEEP_BITS  = 12,
    parameter int unsigned HALF_DIV   = 5,
    parameter int unsigned SETUP_CYC  = 6,
    parameter int unsigned CONV_CYC   = 450,
    parameter int unsigned GAP_CYC    = 13
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic                 adc_miso,
    output logic                 adc_cs_n,
    output logic                 adc_sclk,
    output logic                 busy,
    output logic                 result_valid,
    output logic [KEEP_BITS-1:0] result
);
    import adc_rd_pkg::*;

    localparam int unsigned MAXCNT = max2(max2(HALF_DIV, SETUP_CYC), max2(CONV_CYC, GAP_CYC));
    localparam int unsigned TW     = $clog2(MAXCNT + 1);
    localparam int unsigned BW     = $clog2(FRAME_BITS + 1);

    rd_state_t state_q, state_d;
    logic          tmr_load, tmr_done;
    logic [TW-1:0] tmr_val;
    logic [BW-1:0] bitcnt_q;
    logic          bit_clr, bit_inc, last_bit, shift_en, finish;
    logic [KEEP_BITS-1:0] kept;
    logic [KEEP_BITS-1:0] result_q;
    logic                 valid_q;

    adc_rd_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    adc_rd_shifter #(.FRAME_BITS(FRAME_BITS), .KEEP_BITS(KEEP_BITS)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .clear    (bit_clr),
        .shift_en (shift_en),
        .din      (adc_miso),
        .kept     (kept)
    );

    assign last_bit = (bitcnt_q == BW'(FRAME_BITS - 1));

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and timer control
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        bit_clr  = 1'b0;
        bit_inc  = 1'b0;
        shift_en = 1'b0;
        finish   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d  = ST_SETUP;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(SETUP_CYC - 1);
                    bit_clr  = 1'b1;
                end
            end
            ST_SETUP: begin
                if (tmr_done) begin
                    state_d  = ST_SCLK_HI;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(HALF_DIV - 1);
                end
            end
            ST_SCLK_HI: begin
                if (tmr_done) begin
                    shift_en = 1'b1;
                    bit_inc  = 1'b1;
                    tmr_load = 1'b1;
                    if (last_bit) begin
                        state_d = ST_CONVERT;
                        tmr_val = TW'(CONV_CYC - 1);
                    end else begin
                        state_d = ST_SCLK_LO;
                        tmr_val = TW'(HALF_DIV - 1);
                    end
                end
            end
            ST_SCLK_LO: begin
                if (tmr_done) begin
                    state_d  = ST_SCLK_HI;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(HALF_DIV - 1);
                end
            end
            ST_CONVERT: begin
                if (tmr_done) begin
                    state_d  = ST_GAP;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(GAP_CYC - 1);
                    finish   = 1'b1;
                end
            end
            ST_GAP: begin
                if (tmr_done) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Bit counter and result register
    always_ff @(posedge clk) begin
        if (rst) begin
            bitcnt_q <= '0;
            result_q <= '0;
            valid_q  <= 1'b0;
        end else begin
            if (bit_clr) begin
                bitcnt_q <= '0;
            end else if (bit_inc) begin
                bitcnt_q <= bitcnt_q + 1'b1;
            end
            valid_q <= finish;
            if (finish) begin
                result_q <= kept;
            end
        end
    end

    // Outputs decoded from state
    always_comb begin
        adc_cs_n = (state_q == ST_IDLE) || (state_q == ST_GAP);
        adc_sclk = (state_q == ST_SCLK_HI);
        busy     = (state_q != ST_IDLE);
    end

    assign result_valid = valid_q;
    assign result       = result_q;

    // R2: clock quiet while deselected
    a_r2_sclk_idle_low: assert property (@(posedge clk) disable iff (rst)
        adc_cs_n |-> !adc_sclk);

    // R3: bit counter never passes the frame length
    a_r3_bit_limit: assert property (@(posedge clk) disable iff (rst)
        bitcnt_q <= BW'(FRAME_BITS));

    // R8: strobe lasts one cycle
    a_r8_valid_single: assert property (@(posedge clk) disable iff (rst)
        result_valid |=> !result_valid);

    // R8: strobe coincides with chip-select rising
    a_r8_valid_cs_rise: assert property (@(posedge clk) disable iff (rst)
        result_valid |-> (adc_cs_n && !$past(adc_cs_n)));

    // R9: a selected converter always implies busy
    a_r9_busy_covers_cs: assert property (@(posedge clk) disable iff (rst)
        !adc_cs_n |-> busy);

    // R10: result only moves with the strobe
    a_r10_result_hold: assert property (@(posedge clk) disable iff (rst)
        !result_valid |-> $stable(result));

endmodule

// File: tb/tb_adc_frame_reader.sv
module tb_adc_frame_reader;

    localparam int HALF  = 5;
    localparam int SETUP = 6;
    localparam int CONV  = 450;
    localparam int GAP   = 13;
    localparam int CSLOW = SETUP + 31 * HALF + CONV;
    localparam int NV    = 10;
    localparam logic [15:0] VEC [NV] = '{
        16'h0000, 16'hFFFF, 16'hA5A5, 16'h5A5A, 16'h800F,
        16'h000F, 16'h0010, 16'h7FF0, 16'hFFF0, 16'h1234
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        adc_miso = 1'b0;
    logic        adc_cs_n, adc_sclk, busy, result_valid;
    logic [11:0] result;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    adc_frame_reader dut (
        .clk(clk), .rst(rst), .start(start), .adc_miso(adc_miso),
        .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk), .busy(busy),
        .result_valid(result_valid), .result(result)
    );

    task automatic chk(input string tag, input int act, input int exp_v);
        checks++;
        if (act != exp_v) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
        end
    endtask

    task automatic chk_min(input string tag, input int act, input int min_v);
        checks++;
        if (act < min_v) begin
            errors++;
            $display("FAIL %s actual=%0d expected>=%0d", tag, act, min_v);
        end
    endtask

    // Converter model: MSB out at select, next bit on each rising clock
    logic [15:0] adc_word = 16'h0000;
    int nfall = 0;
    always @(negedge adc_cs_n) begin
        nfall    = 0;
        adc_miso = adc_word[15];
    end
    always @(negedge adc_sclk) nfall = nfall + 1;
    always @(posedge adc_sclk) begin
        if (nfall < 16) adc_miso = adc_word[15 - nfall];
    end

    // Pin timing monitor, sampled on the falling system edge
    logic m_cs = 1'b1, m_sclk = 1'b0, m_valid = 1'b0, m_seen = 1'b0, m_first = 1'b0;
    int cs_run = 0, sclk_run = 0, falls = 0, since_fall = 0, cs_falls = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (adc_sclk != m_sclk) begin
                if (adc_sclk) begin
                    if (m_first) chk("R5 setup cycles", cs_run, SETUP);
                    else chk("R3 low phase", sclk_run, HALF);
                    m_first = 1'b0;
                end else begin
                    chk("R3 high phase", sclk_run, HALF);
                    falls++;
                    since_fall = 0;
                end
                sclk_run = 1;
            end else begin
                sclk_run++;
            end
            if (adc_sclk) chk("R2 sclk low when deselected", int'(adc_cs_n), 0);
            if (adc_cs_n != m_cs) begin
                if (adc_cs_n) begin
                    chk("R6 chip-select low time", cs_run, CSLOW);
                    chk("R6 hold after last edge", since_fall, CONV);
                    chk("R3 pulses per frame", falls, 16);
                end else begin
                    if (m_seen) chk_min("R7 recovery gap", cs_run, GAP);
                    m_seen = 1'b1;
                    m_first = 1'b1;
                    falls = 0;
                    cs_falls++;
                end
                cs_run = 1;
            end else begin
                cs_run++;
            end
            since_fall++;
            if (result_valid) begin
                chk("R8 valid at cs rise", int'({m_cs, adc_cs_n}), 1);
                chk("R8 single-cycle valid", int'(m_valid), 0);
            end
            m_cs    = adc_cs_n;
            m_sclk  = adc_sclk;
            m_valid = result_valid;
        end
    end

    task automatic wait_valid();
        for (int k = 0; k < 2000; k++) begin
            @(negedge clk);
            if (result_valid) return;
        end
        chk("R8 valid never seen", 0, 1);
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 2000; k++) begin
            @(negedge clk);
            if (!busy) return;
        end
        chk("R9 busy never dropped", 1, 0);
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin
        int fall_base;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk("R1 cs_n", int'(adc_cs_n), 1);
        chk("R1 sclk", int'(adc_sclk), 0);
        chk("R1 busy", int'(busy), 0);
        chk("R1 valid", int'(result_valid), 0);
        chk("R1 result", int'(result), 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R4 table of data patterns
        for (int i = 0; i < NV; i++) begin
            adc_word = VEC[i];
            pulse_start();
            chk("R9 busy after start", int'(busy), 1);
            wait_valid();
            chk("R4 result bits 15..4", int'(result), int'(VEC[i][15:4]));
            wait_idle();
        end

        // R9 start while busy is ignored
        adc_word  = 16'hC3A7;
        fall_base = cs_falls;
        pulse_start();
        repeat (40) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (300) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_valid();
        chk("R4 result after ignored starts", int'(result), 16'hC3A);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_idle();
        repeat (40) @(negedge clk);
        chk("R9 only one frame for busy starts", cs_falls - fall_base, 1);
        chk("R9 idle after frame", int'(busy), 0);

        // R10 result holds while idle with a different word at the pins
        adc_word = 16'h0FF5;
        repeat (50) @(negedge clk);
        chk("R10 result held", int'(result), 16'hC3A);

        // R7 back-to-back frames with start held
        adc_word = 16'h9876;
        @(negedge clk);
        start = 1'b1;
        wait_valid();
        chk("R4 first back-to-back", int'(result), 16'h987);
        adc_word = 16'h4321;
        wait_valid();
        chk("R4 second back-to-back", int'(result), 16'h432);
        start = 1'b0;
        wait_idle();
        repeat (20) @(negedge clk);
        chk("R2 cs idle high", int'(adc_cs_n), 1);

        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule